// File: doc/BRIEF.md
# Register-Reference Execution Unit

This block carries out the accumulator-only instruction group of a small 16-bit accumulator machine in a single clock. It holds the accumulator and the one-bit extension flag that sits to the left of it. The control sequencer raises a fire strobe when the current instruction belongs to this group and the timing step has been reached. A 12-bit selection field, taken from the low bits of the instruction, names the work to do, with one bit for each operation.

In the same cycle as an accepted fire, the unit raises three strobes. The first clears the sequence counter. The second tells the program counter to step once more, which skips the next instruction. The third reports a halt. The unit also owns the run flag that lets the sequence counter advance. A halt operation drops that flag. Only the external start pulse raises it again. While the flag is low, fire is ignored.

Top module: `regref_exec_unit`

## Requirements
- R1: After synchronous reset the accumulator is 0, the extension flag is 0 and the run flag is 0.
- R2: A fire is accepted only while the run flag is 1. Without an accepted fire, the accumulator and extension flag keep their values, and the sequence-clear, skip and halt strobes stay low.
- R3: Selection bit 11 clears the accumulator and bit 10 clears the extension flag. Neither touches the other register.
- R4: Selection bit 9 inverts every accumulator bit and bit 8 inverts the extension flag.
- R5: Selection bit 7 rotates the 17-bit pair {flag, accumulator} right. Accumulator bit 0 goes to the flag and the old flag enters accumulator bit 15.
- R6: Selection bit 6 rotates the pair left. Accumulator bit 15 goes to the flag and the old flag enters accumulator bit 0.
- R7: Selection bit 5 adds 1 to the accumulator modulo 2^16, wrapping 0xFFFF to 0x0000. The flag is left unchanged.
- R8: The skip strobe is high during an accepted fire whenever any of these holds, each judged on the values held before the clock edge: bit 4 is set and accumulator bit 15 is 0; bit 3 is set and accumulator bit 15 is 1; bit 2 is set and the accumulator is 0; bit 1 is set and the flag is 0.
- R9: Selection bit 0 raises the halt strobe, and the run flag is 0 after that edge. A start pulse sets the run flag at the next edge. If halt and start arrive in the same cycle, halt wins.
- R10: The sequence-clear strobe is high exactly in the cycles where fire is high and the run flag is 1.
- R11: When several selection bits are set, they act in this order on one word: clears, then inversions, then right rotate, then left rotate, then increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fire_i | input | 1 | Group-select and timing-step strobe from the sequencer |
| sel_i | input | 12 | One-bit-per-operation selection field |
| start_i | input | 1 | External start pulse that sets the run flag |
| acc_o | output | DATA_W | Accumulator register |
| ext_o | output | 1 | Extension flag register |
| skip_o | output | 1 | Extra program-counter increment strobe |
| halt_o | output | 1 | Halt strobe, clearing the run flag |
| run_o | output | 1 | Run flag; the sequence counter advances while it is 1 |
| sc_clr_o | output | 1 | Sequence-counter clear strobe |

## Verification
The bench builds the unit with its default 16-bit data width. At that width the sign bit is bit 15, the increment wraps at 0xFFFF, and any accumulator value can be loaded through sixteen left rotations that feed the flag in, which takes only a few hundred cycles. With these values the bench can reach both sides of every skip condition, both rotation carries, and both the increment wrap and the sign crossing.

// File: rtl/regref_pkg.sv
`timescale 1ns/1ps
package regref_pkg;
  localparam int SEL_W = 12;

  // Bit order matches the selection field, MSB first.
  typedef struct packed {
    logic clr_acc;   // 11
    logic clr_ext;   // 10
    logic inv_acc;   // 9
    logic inv_ext;   // 8
    logic rot_rt;    // 7
    logic rot_lt;    // 6
    logic incr;      // 5
    logic sk_pos;    // 4
    logic sk_neg;    // 3
    logic sk_zero;   // 2
    logic sk_ext0;   // 1
    logic stop;      // 0
  } rr_op_t;
endpackage

// File: rtl/regref_decode.sv
`timescale 1ns/1ps
module regref_decode
  import regref_pkg::*;
(
  input  logic             fire_i,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output rr_op_t           op_o,
  output logic             accept_o
);
  logic [SEL_W-1:0] en;

  assign accept_o = fire_i & run_i;

  for (genvar i = 0; i < SEL_W; i++) begin : g_en
    assign en[i] = accept_o & sel_i[i];
  end

  assign op_o = rr_op_t'(en);
endmodule

// File: rtl/regref_accum.sv
`timescale 1ns/1ps
module regref_accum
  import regref_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  rr_op_t            op_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              ext_o
);
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] acc_q, acc_n;
  logic              ext_q, ext_n, spill;

  // Stages applied in fixed order on one word (R11).
  always_comb begin
    acc_n = acc_q;
    ext_n = ext_q;
    spill = 1'b0;
    if (op_i.clr_acc) acc_n = '0;
    if (op_i.clr_ext) ext_n = 1'b0;
    if (op_i.inv_acc) acc_n = ~acc_n;
    if (op_i.inv_ext) ext_n = ~ext_n;
    if (op_i.rot_rt) begin
      spill = acc_n[0];
      acc_n = {ext_n, acc_n[DATA_W-1:1]};
      ext_n = spill;
    end
    if (op_i.rot_lt) begin
      spill = acc_n[DATA_W-1];
      acc_n = {acc_n[DATA_W-2:0], ext_n};
      ext_n = spill;
    end
    if (op_i.incr) acc_n = acc_n + ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      ext_q <= 1'b0;
    end else begin
      acc_q <= acc_n;
      ext_q <= ext_n;
    end
  end

  assign acc_o = acc_q;
  assign ext_o = ext_q;
endmodule

// File: rtl/regref_cond.sv
`timescale 1ns/1ps
module regref_cond
  import regref_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  rr_op_t            op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic              ext_i,
  output logic              skip_o
);
  logic sign, zero;

  assign sign   = acc_i[DATA_W-1];
  assign zero   = ~|acc_i;
  assign skip_o = (op_i.sk_pos  & ~sign) |
                  (op_i.sk_neg  &  sign) |
                  (op_i.sk_zero &  zero) |
                  (op_i.sk_ext0 & ~ext_i);
endmodule

// File: rtl/regref_runctl.sv
`timescale 1ns/1ps
module regref_runctl (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic halt_i,
  output logic run_o
);
  logic run_q;

  always_ff @(posedge clk) begin
    if (rst)          run_q <= 1'b0;
    else if (halt_i)  run_q <= 1'b0;
    else if (start_i) run_q <= 1'b1;
  end

  assign run_o = run_q;
endmodule

// File: rtl/regref_exec_unit.sv
`timescale 1ns/1ps
module regref_exec_unit
  import regref_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire_i,
  input  logic [11:0]       sel_i,
  input  logic              start_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              ext_o,
  output logic              skip_o,
  output logic              halt_o,
  output logic              run_o,
  output logic              sc_clr_o
);
  rr_op_t op;
  logic   accept;

  regref_decode i_decode (
    .fire_i   (fire_i),
    .run_i    (run_o),
    .sel_i    (sel_i),
    .op_o     (op),
    .accept_o (accept)
  );

  regref_accum #(.DATA_W(DATA_W)) i_accum (
    .clk   (clk),
    .rst   (rst),
    .op_i  (op),
    .acc_o (acc_o),
    .ext_o (ext_o)
  );

  regref_cond #(.DATA_W(DATA_W)) i_cond (
    .op_i   (op),
    .acc_i  (acc_o),
    .ext_i  (ext_o),
    .skip_o (skip_o)
  );

  regref_runctl i_runctl (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .halt_i  (op.stop),
    .run_o   (run_o)
  );

  assign halt_o   = op.stop;
  assign sc_clr_o = accept;
endmodule

// File: rtl/regref_checker.sv
`timescale 1ns/1ps
module regref_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              fire_i,
  input logic [11:0]       sel_i,
  input logic              start_i,
  input logic [DATA_W-1:0] acc_o,
  input logic              ext_o,
  input logic              skip_o,
  input logic              halt_o,
  input logic              run_o,
  input logic              sc_clr_o
);
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(fire_i && run_o) |=> $stable(acc_o) && $stable(ext_o));

  p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !run_o |-> !sc_clr_o && !skip_o && !halt_o);

  p_cla_r3: assert property (@(posedge clk) disable iff (rst)
    fire_i && run_o && sel_i == 12'h800 |=> acc_o == '0 && ext_o == $past(ext_o));

  p_cma_r4: assert property (@(posedge clk) disable iff (rst)
    fire_i && run_o && sel_i == 12'h200 |=> acc_o == ~$past(acc_o));

  p_cir_r5: assert property (@(posedge clk) disable iff (rst)
    fire_i && run_o && sel_i == 12'h080 |=>
      acc_o == {$past(ext_o), $past(acc_o[DATA_W-1:1])} && ext_o == $past(acc_o[0]));

  p_cil_r6: assert property (@(posedge clk) disable iff (rst)
    fire_i && run_o && sel_i == 12'h040 |=>
      acc_o == {$past(acc_o[DATA_W-2:0]), $past(ext_o)} && ext_o == $past(acc_o[DATA_W-1]));

  p_inc_r7: assert property (@(posedge clk) disable iff (rst)
    fire_i && run_o && sel_i == 12'h020 |=>
      acc_o == $past(acc_o) + 1'b1 && ext_o == $past(ext_o));

  p_sza_r8: assert property (@(posedge clk) disable iff (rst)
    fire_i && run_o && sel_i == 12'h004 |-> skip_o == (acc_o == '0));

  p_sna_r8: assert property (@(posedge clk) disable iff (rst)
    fire_i && run_o && sel_i == 12'h008 |-> skip_o == acc_o[DATA_W-1]);

  p_halt_r9: assert property (@(posedge clk) disable iff (rst)
    halt_o |=> !run_o);

  p_start_r9: assert property (@(posedge clk) disable iff (rst)
    start_i && !halt_o |=> run_o);

  p_clr_r10: assert property (@(posedge clk) disable iff (rst)
    sc_clr_o |-> fire_i && run_o);

  p_clr_seen_r10: assert property (@(posedge clk) disable iff (rst)
    fire_i && run_o |-> sc_clr_o);
endmodule

bind regref_exec_unit regref_checker #(.DATA_W(DATA_W)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .fire_i   (fire_i),
  .sel_i    (sel_i),
  .start_i  (start_i),
  .acc_o    (acc_o),
  .ext_o    (ext_o),
  .skip_o   (skip_o),
  .halt_o   (halt_o),
  .run_o    (run_o),
  .sc_clr_o (sc_clr_o)
);

// File: tb/test_regref_exec_unit.sv
`timescale 1ns/1ps
module test_regref_exec_unit;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fire_i = 1'b0;
  logic [11:0]   sel_i = '0;
  logic          start_i = 1'b0;
  logic [DW-1:0] acc_o;
  logic          ext_o, skip_o, halt_o, run_o, sc_clr_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference state
  logic [DW-1:0] m_ac = '0;
  logic          m_e = 1'b0;
  logic          m_run = 1'b0;
  // Captured strobes and their expectations for the last exec
  logic c_skip, c_halt, c_clr, x_skip, x_halt, x_clr;

  always #10 clk = ~clk;

  regref_exec_unit #(.DATA_W(DW)) i_regref_exec_unit (
    .clk(clk), .rst(rst), .fire_i(fire_i), .sel_i(sel_i), .start_i(start_i),
    .acc_o(acc_o), .ext_o(ext_o), .skip_o(skip_o), .halt_o(halt_o),
    .run_o(run_o), .sc_clr_o(sc_clr_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [11:0] s);
    logic t;
    x_clr  = m_run;
    x_skip = m_run & ((s[4] & ~m_ac[DW-1]) | (s[3] & m_ac[DW-1]) |
                      (s[2] & (m_ac == '0)) | (s[1] & ~m_e));
    x_halt = m_run & s[0];
    if (m_run) begin
      if (s[11]) m_ac = '0;
      if (s[10]) m_e = 1'b0;
      if (s[9])  m_ac = ~m_ac;
      if (s[8])  m_e = ~m_e;
      if (s[7]) begin t = m_ac[0]; m_ac = {m_e, m_ac[DW-1:1]}; m_e = t; end
      if (s[6]) begin t = m_ac[DW-1]; m_ac = {m_ac[DW-2:0], m_e}; m_e = t; end
      if (s[5])  m_ac = m_ac + 1'b1;
      if (s[0])  m_run = 1'b0;
    end
  endtask

  task automatic exec(input logic [11:0] s);
    @(negedge clk);
    fire_i = 1'b1; sel_i = s;
    #1;
    c_skip = skip_o; c_halt = halt_o; c_clr = sc_clr_o;
    model(s);
    @(negedge clk);
    fire_i = 1'b0; sel_i = '0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    m_run = 1'b1;
  endtask

  task automatic set_e(input logic b);
    exec(b ? 12'h500 : 12'h400);
  endtask

  // Load any value through sixteen left rotations (also uses R11 ordering)
  task automatic load(input logic [DW-1:0] v);
    exec(12'hC00);
    for (int i = DW - 1; i >= 0; i--) exec(v[i] ? 12'h540 : 12'h440);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 acc", acc_o, 0);
    chk("R1 ext", ext_o, 0);
    chk("R1 run", run_o, 0);
  endtask

  task automatic t_halt();
    pulse_start();
    chk("R9 start sets run", run_o, 1);
    load(16'h1234);
    chk("R2 load path", acc_o, 16'h1234);
    exec(12'h001);
    chk("R9 halt strobe", c_halt, 1);
    chk("R9 run cleared", run_o, 0);
    exec(12'h200);
    chk("R2 stopped no clear", c_clr, 0);
    chk("R2 stopped acc held", acc_o, 16'h1234);
    exec(12'h004);
    chk("R2 stopped no skip", c_skip, 0);
    pulse_start();
    chk("R9 restart", run_o, 1);
    @(negedge clk);
    fire_i = 1'b1; sel_i = 12'h001; start_i = 1'b1;
    @(negedge clk);
    fire_i = 1'b0; sel_i = '0; start_i = 1'b0;
    m_run = 1'b0;
    chk("R9 halt beats start", run_o, 0);
    pulse_start();
  endtask

  task automatic t_clear();
    load(16'hBEEF);
    set_e(1'b1);
    exec(12'h800);
    chk("R3 CLA acc", acc_o, 0);
    chk("R3 CLA keeps ext", ext_o, 1);
    chk("R10 clear strobe", c_clr, 1);
    load(16'h00A5);
    set_e(1'b1);
    exec(12'h400);
    chk("R3 CLE ext", ext_o, 0);
    chk("R3 CLE keeps acc", acc_o, 16'h00A5);
  endtask

  task automatic t_comp();
    load(16'h0F0F);
    exec(12'h200);
    chk("R4 CMA", acc_o, 16'hF0F0);
    exec(12'h100);
    chk("R4 CME", ext_o, 1);
    chk("R4 CME keeps acc", acc_o, 16'hF0F0);
  endtask

  task automatic t_rot();
    load(16'h8001);
    set_e(1'b0);
    exec(12'h080);
    chk("R5 CIR acc", acc_o, 16'h4000);
    chk("R5 CIR ext", ext_o, 1);
    exec(12'h080);
    chk("R5 CIR ext in", acc_o, 16'hA000);
    chk("R5 CIR ext out", ext_o, 0);
    exec(12'h040);
    chk("R6 CIL acc", acc_o, 16'h4000);
    chk("R6 CIL ext", ext_o, 1);
    exec(12'h040);
    chk("R6 CIL ext in", acc_o, 16'h8001);
    chk("R6 CIL ext out", ext_o, 0);
  endtask

  task automatic t_inc();
    load(16'hFFFF);
    set_e(1'b1);
    exec(12'h020);
    chk("R7 INC wrap", acc_o, 16'h0000);
    chk("R7 INC keeps ext", ext_o, 1);
    load(16'h7FFF);
    exec(12'h020);
    chk("R7 INC sign cross", acc_o, 16'h8000);
  endtask

  task automatic t_skip();
    logic [DW-1:0] vals [3] = '{16'h0000, 16'h0001, 16'h8000};
    for (int v = 0; v < 3; v++) begin
      for (int e = 0; e < 2; e++) begin
        for (int b = 1; b <= 4; b++) begin
          load(vals[v]);
          set_e(e[0]);
          exec(12'(1 << b));
          chk("R8 skip", c_skip, x_skip);
          chk("R10 clear on skip op", c_clr, x_clr);
          chk("R8 skip leaves acc", acc_o, m_ac);
        end
      end
    end
  endtask

  task automatic t_combo();
    exec(12'hD60);
    chk("R11 combo acc", acc_o, 16'h0002);
    chk("R11 combo ext", ext_o, 0);
    exec(12'hA00);
    chk("R11 clear then invert", acc_o, 16'hFFFF);
  endtask

  initial begin
    t_reset();
    t_halt();
    t_clear();
    t_comp();
    t_rot();
    t_inc();
    t_skip();
    t_combo();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule